// File: doc/BRIEF.md
# Aligned Vector Indexed Load Unit

This block executes a single kind of instruction: a 128-bit vector load from an address built from two general registers. It accepts a 32-bit instruction word through a valid/ready handshake and recognises two encodings. The first is a standard form that names one of 32 vector registers. The second is an extended form whose 7-bit destination index reaches 128 vector registers. When a word matches neither encoding, the block rejects it with a one-cycle illegal pulse.

For a legal word, the block reads a base value and an offset value from a combinational general-register read port. A base field of zero stands for the constant zero. The block adds base and offset, truncates the sum to 32 bits and clears its low four bits. It then fetches the 16 bytes of the aligned block one at a time over a byte memory port that has variable latency. The bytes are packed most-significant-first. The whole vector is written to the destination register in one cycle, and a done pulse is raised in that same cycle.

Top module: `vload_unit`

## Requirements
- R1: A word is the standard form when `(word & 0xFC0007FF) == 0x7C0000CE`. Bit 0 (the LSB) must be 0, and the register fields are ignored for matching. The destination is `{2'b00, word[25:21]}`, the base field is `word[20:16]` and the offset field is `word[15:11]`.
- R2: A word is the extended form when `(word & 0xFC0007F3) == 0x100000C3`. The destination is `{word[3:2], word[25:21]}`, which covers registers 0 to 127. The base and offset fields are in the same places as in R1.
- R3: Any other accepted word raises `illegal` for exactly the one cycle after acceptance. It causes no memory read and no vector write.
- R4: When the base field is 0, the base is the constant zero and the value on `gpr_a_data` is ignored.
- R5: The load address is bits 31:0 of the 64-bit wrapping sum base+offset, with bits 3:0 cleared. An unaligned sum raises no error.
- R6: A legal word produces exactly 16 single-cycle `mem_req` pulses at addresses EA+0 through EA+15, in order. Each request after the first waits for the `mem_rvalid` of the previous one. The first request is issued in the cycle after acceptance.
- R7: The byte read from EA lands in `vr_data[127:120]`, and the byte from EA+15 lands in `vr_data[7:0]`.
- R8: `vr_we` and `done` are high together for one cycle, once per legal word, with all 128 bits of `vr_data` valid in that cycle.
- R9: `insn_ready` is high only while the unit is idle. `insn_valid` while busy has no effect on the requests or on the result.
- R10: After reset, `insn_ready` is 1 and `mem_req`, `vr_we`, `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit idle, word will be taken |
| insn_word | input | 32 | Instruction word |
| gpr_a_idx | output | 5 | Base register index (combinational from insn_word) |
| gpr_b_idx | output | 5 | Offset register index (combinational from insn_word) |
| gpr_a_data | input | 64 | Base register contents, same cycle |
| gpr_b_data | input | 64 | Offset register contents, same cycle |
| mem_req | output | 1 | Byte read request pulse |
| mem_addr | output | 32 | Byte read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| vr_we | output | 1 | Vector register write enable |
| vr_idx | output | 7 | Vector register index |
| vr_data | output | 128 | Vector written, lane 0 in the top byte |
| done | output | 1 | Load completed, coincident with vr_we |
| illegal | output | 1 | Rejected instruction pulse |

## Verification
The bench targets the following corner cases:
- A base field of 0 while register 0 holds a large nonzero value. A unit that read the register would fetch from a different block.
- Unaligned sums, a sum that wraps past 2^64, and a sum that carries into bit 32. Each of these exposes a missing alignment mask, a missing truncation, or an aligned address computed before the addition.
- Extended destinations 33, 64 and 127. Swapped or dropped high destination bits would write the wrong register.
- Near-miss words: the LSB set, a neighbouring sub-opcode, and an extended word with cleared reserved bits. A loose decoder would load on these instead of pulsing illegal.
- A new word offered during a busy load. This catches a unit that restarts or double-writes.

// File: rtl/vload_pkg.sv
package vload_pkg;
  localparam int INSN_W = 32;
  localparam logic [INSN_W-1:0] STD_MASK  = 32'hFC0007FF;
  localparam logic [INSN_W-1:0] STD_MATCH = 32'h7C0000CE;
  localparam logic [INSN_W-1:0] EXT_MASK  = 32'hFC0007F3;
  localparam logic [INSN_W-1:0] EXT_MATCH = 32'h100000C3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic       is_std;
    logic       is_ext;
    logic [6:0] dest;
    logic [4:0] base_f;
    logic [4:0] offs_f;
  } dec_t;
endpackage

// File: rtl/vload_decode.sv
module vload_decode
  import vload_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec,
  output logic              legal
);
  always_comb begin
    dec.is_std = ((insn & STD_MASK) == STD_MATCH);
    dec.is_ext = ((insn & EXT_MASK) == EXT_MATCH);
    dec.base_f = insn[20:16];
    dec.offs_f = insn[15:11];
    if (dec.is_ext) dec.dest = {insn[3:2], insn[25:21]};
    else            dec.dest = {2'b00, insn[25:21]};
    legal = dec.is_std | dec.is_ext;
  end
endmodule

// File: rtl/vload_agen.sv
module vload_agen #(
  parameter int GPR_W   = 64,
  parameter int ADDR_W  = 32,
  parameter int ALIGN_B = 16
) (
  input  logic [4:0]        base_f,
  input  logic [GPR_W-1:0]  base_val,
  input  logic [GPR_W-1:0]  offs_val,
  output logic [ADDR_W-1:0] ea
);
  localparam int LOW_W = $clog2(ALIGN_B);

  function automatic logic [ADDR_W-1:0] eff_addr(
    input logic              zero_base,
    input logic [GPR_W-1:0]  b,
    input logic [GPR_W-1:0]  o
  );
    logic [GPR_W-1:0] sum;
    sum = (zero_base ? '0 : b) + o;
    return {sum[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
  endfunction

  assign ea = eff_addr(base_f == 5'd0, base_val, offs_val);
endmodule

// File: rtl/vload_seq.sv
module vload_seq
  import vload_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VEC_BYTES = 16,
  parameter int DST_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 reject,
  input  logic [ADDR_W-1:0]    ea_in,
  input  logic [DST_W-1:0]     dst_in,
  output logic                 idle,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_rvalid,
  input  logic [7:0]           mem_rdata,
  output logic                 vr_we,
  output logic [DST_W-1:0]     vr_idx,
  output logic [8*VEC_BYTES-1:0] vr_data,
  output logic                 illegal,
  output logic                 byte_take,
  output logic                 last_byte
);
  localparam int VEC_W = 8 * VEC_BYTES;
  localparam int OFS_W = $clog2(VEC_BYTES);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(VEC_BYTES - 1);

  seq_state_t          st;
  logic [ADDR_W-1:0]   base_q;
  logic [DST_W-1:0]    dst_q;
  logic [OFS_W-1:0]    cnt;
  logic [VEC_W-1:0]    shreg;
  logic                illegal_q;

  assign idle      = (st == ST_IDLE);
  assign mem_req   = (st == ST_ISSUE);
  assign mem_addr  = {base_q[ADDR_W-1:OFS_W], cnt};
  assign byte_take = (st == ST_WAIT) && mem_rvalid;
  assign last_byte = byte_take && (cnt == LAST);
  assign vr_we     = (st == ST_WRITE);
  assign vr_idx    = dst_q;
  assign vr_data   = shreg;
  assign illegal   = illegal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      base_q    <= '0;
      dst_q     <= '0;
      cnt       <= '0;
      shreg     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= reject;
      unique case (st)
        ST_IDLE: if (start) begin
          base_q <= ea_in;
          dst_q  <= dst_in;
          cnt    <= '0;
          st     <= ST_ISSUE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (byte_take) begin
          shreg <= {shreg[VEC_W-9:0], mem_rdata};
          if (last_byte) st <= ST_WRITE;
          else begin
            cnt <= cnt + 1'b1;
            st  <= ST_ISSUE;
          end
        end
        ST_WRITE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vload_unit.sv
module vload_unit
  import vload_pkg::*;
#(
  parameter int GPR_W     = 64,
  parameter int ADDR_W    = 32,
  parameter int VEC_BYTES = 16,
  parameter int DST_W     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   insn_valid,
  output logic                   insn_ready,
  input  logic [INSN_W-1:0]      insn_word,
  output logic [4:0]             gpr_a_idx,
  output logic [4:0]             gpr_b_idx,
  input  logic [GPR_W-1:0]       gpr_a_data,
  input  logic [GPR_W-1:0]       gpr_b_data,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_rvalid,
  input  logic [7:0]             mem_rdata,
  output logic                   vr_we,
  output logic [DST_W-1:0]       vr_idx,
  output logic [8*VEC_BYTES-1:0] vr_data,
  output logic                   done,
  output logic                   illegal
);
  dec_t              dec;
  logic              insn_legal;
  logic              idle;
  logic              accept_evt;
  logic              start_evt;
  logic              reject_evt;
  logic [ADDR_W-1:0] ea;
  logic              byte_take;
  logic              last_byte;

  vload_decode u_dec (
    .insn  (insn_word),
    .dec   (dec),
    .legal (insn_legal)
  );

  assign gpr_a_idx = dec.base_f;
  assign gpr_b_idx = dec.offs_f;

  vload_agen #(.GPR_W(GPR_W), .ADDR_W(ADDR_W), .ALIGN_B(VEC_BYTES)) u_agen (
    .base_f   (dec.base_f),
    .base_val (gpr_a_data),
    .offs_val (gpr_b_data),
    .ea       (ea)
  );

  assign insn_ready = idle;
  assign accept_evt = insn_valid && idle;
  assign start_evt  = accept_evt && insn_legal;
  assign reject_evt = accept_evt && !insn_legal;

  vload_seq #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .DST_W(DST_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .reject     (reject_evt),
    .ea_in      (ea),
    .dst_in     (dec.dest[DST_W-1:0]),
    .idle       (idle),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .vr_we      (vr_we),
    .vr_idx     (vr_idx),
    .vr_data    (vr_data),
    .illegal    (illegal),
    .byte_take  (byte_take),
    .last_byte  (last_byte)
  );

  assign done = vr_we;
endmodule

// File: rtl/vload_chk.sv
module vload_chk #(
  parameter int VEC_BYTES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic insn_ready,
  input logic accept_evt,
  input logic insn_legal,
  input logic mem_req,
  input logic byte_take,
  input logic last_byte,
  input logic vr_we,
  input logic done,
  input logic illegal
);
  localparam int CW = $clog2(VEC_BYTES) + 2;
  logic [CW-1:0] req_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          req_cnt <= '0;
    else if (accept_evt) req_cnt <= '0;
    else if (mem_req)    req_cnt <= req_cnt + 1'b1;
  end

  assert_reject_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !insn_legal) |=> (illegal && !mem_req && !vr_we));
  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, vr_we, illegal}));
  assert_first_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && insn_legal) |=> mem_req);
  assert_req_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vr_we |-> (req_cnt == CW'(VEC_BYTES)));
  assert_last_then_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> vr_we);
  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vr_we |=> !vr_we);
  assert_done_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vr_we);
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || byte_take || vr_we) |-> !insn_ready);
  assert_back_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vr_we |=> insn_ready);
endmodule

bind vload_unit vload_chk #(.VEC_BYTES(VEC_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .insn_ready (insn_ready),
  .accept_evt (accept_evt),
  .insn_legal (insn_legal),
  .mem_req    (mem_req),
  .byte_take  (byte_take),
  .last_byte  (last_byte),
  .vr_we      (vr_we),
  .done       (done),
  .illegal    (illegal)
);

// File: tb/vload_unit_tb.sv
module vload_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         insn_valid = 1'b0;
  logic         insn_ready;
  logic [31:0]  insn_word = '0;
  logic [4:0]   gpr_a_idx, gpr_b_idx;
  logic [63:0]  gpr_a_data, gpr_b_data;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [7:0]   mem_rdata = '0;
  logic         vr_we;
  logic [6:0]   vr_idx;
  logic [127:0] vr_data;
  logic         done;
  logic         illegal;

  logic [63:0]  gpr [32];
  int           lat = 1;
  int           pcnt = 0;
  logic [31:0]  paddr = '0;
  logic [31:0]  addr_log [4096];
  int           n_req = 0;
  int           we_cnt = 0;
  int           checks = 0;
  int           errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign gpr_a_data = gpr[gpr_a_idx];
  assign gpr_b_data = gpr[gpr_b_idx];

  vload_unit u_dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .gpr_a_idx(gpr_a_idx), .gpr_b_idx(gpr_b_idx),
    .gpr_a_data(gpr_a_data), .gpr_b_data(gpr_b_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .vr_we(vr_we), .vr_idx(vr_idx), .vr_data(vr_data), .done(done), .illegal(illegal)
  );

  function automatic logic [7:0] mem_f(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  // byte memory with programmable latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      paddr <= mem_addr;
      pcnt  <= lat;
      addr_log[n_req % 4096] <= mem_addr;
      n_req <= n_req + 1;
    end else if (pcnt != 0) begin
      pcnt <= pcnt - 1;
      if (pcnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_f(paddr);
      end
    end
    if (vr_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] std_word(input int d, input int a, input int b);
    return 32'h7C0000CE | (32'(d) << 21) | (32'(a) << 16) | (32'(b) << 11);
  endfunction

  function automatic logic [31:0] ext_word(input int d, input int a, input int b);
    return 32'h100000C3 | (32'(d & 31) << 21) | (32'(a) << 16) | (32'(b) << 11)
           | (32'((d >> 5) & 3) << 2);
  endfunction

  // reference: base is zero for field 0, 64-bit wrap, keep 32 bits, clear low nibble
  function automatic logic [31:0] ref_ea(input int a, input int b);
    logic [63:0] s;
    s = ((a == 0) ? 64'd0 : gpr[a]) + gpr[b];
    return s[31:0] & ~32'hF;
  endfunction

  task automatic do_load(input logic [31:0] w, input int d, input int a, input int b,
                         input int l, input string tag);
    logic [31:0]  ea;
    logic [127:0] exp_v;
    int base, we0, cyc;
    bit addr_ok;
    lat = l;
    ea = ref_ea(a, b);
    for (int i = 0; i < 16; i++) exp_v[127-8*i -: 8] = mem_f(ea + 32'(i));
    @(negedge clk);
    base = n_req; we0 = we_cnt;
    insn_word = w; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(mem_req === 1'b1, {tag, " R6 first request"}, 128'(mem_req), 128'd1);
    cyc = 0;
    while (done !== 1'b1 && cyc < 500) begin @(negedge clk); cyc++; end
    chk(done === 1'b1 && vr_we === 1'b1, {tag, " R8 done with write"},
        128'({done, vr_we}), 128'd3);
    chk(vr_idx == 7'(d), {tag, " R1/R2 destination"}, 128'(vr_idx), 128'(d));
    chk(vr_data == exp_v, {tag, " R7 lane order / R4 R5 address"}, vr_data, exp_v);
    addr_ok = (n_req - base == 16);
    for (int i = 0; i < 16; i++)
      if (addr_log[(base + i) % 4096] != ea + 32'(i)) addr_ok = 0;
    chk(addr_ok, {tag, " R5 R6 request addresses"}, 128'(addr_log[base % 4096]), 128'(ea));
    @(negedge clk);
    chk(done === 1'b0 && we_cnt == we0 + 1, {tag, " R8 single pulse"},
        128'(we_cnt - we0), 128'd1);
  endtask

  task automatic test_reset;
    chk(insn_ready === 1'b1 && mem_req === 1'b0 && vr_we === 1'b0 &&
        done === 1'b0 && illegal === 1'b0, "R10 reset state",
        128'({insn_ready, mem_req, vr_we, done, illegal}), 128'b10000);
  endtask

  task automatic test_std_basic;
    gpr[3] = 64'h1000; gpr[4] = 64'h20;
    do_load(std_word(5, 3, 4), 5, 3, 4, 1, "std basic R1");
  endtask

  task automatic test_unaligned;
    gpr[10] = 64'h1003; gpr[11] = 64'h0A;
    do_load(std_word(31, 10, 11), 31, 10, 11, 2, "unaligned R5");
  endtask

  task automatic test_zero_base;
    gpr[0] = 64'hDEAD_BEEF_0000_5500; gpr[6] = 64'h2_0037;
    do_load(std_word(0, 0, 6), 0, 0, 6, 1, "zero base R4");
  endtask

  task automatic test_wrap;
    gpr[7] = 64'hFFFF_FFFF_FFFF_FFF8; gpr[8] = 64'h15;
    do_load(std_word(9, 7, 8), 9, 7, 8, 3, "wrap64 R5");
    gpr[12] = 64'h0000_0000_FFFF_FFF0; gpr[13] = 64'h25;
    do_load(std_word(2, 12, 13), 2, 12, 13, 1, "carry32 R5");
    gpr[14] = 64'h1234_5678_0000_4ABC; gpr[15] = 64'h0;
    do_load(std_word(17, 14, 15), 17, 14, 15, 2, "upper bits R5");
  endtask

  task automatic test_ext;
    gpr[20] = 64'h8000_0100; gpr[21] = 64'h7;
    do_load(ext_word(127, 20, 21), 127, 20, 21, 1, "ext 127 R2");
    do_load(ext_word(33, 20, 21), 33, 20, 21, 2, "ext 33 R2");
    do_load(ext_word(64, 0, 21), 64, 0, 21, 1, "ext 64 zero base R2");
  endtask

  task automatic test_illegal(input logic [31:0] w, input string tag);
    int base, we0;
    @(negedge clk);
    base = n_req; we0 = we_cnt;
    insn_word = w; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(illegal === 1'b1 && insn_ready === 1'b1, {tag, " R3 illegal pulse"},
        128'({illegal, insn_ready}), 128'd3);
    @(negedge clk);
    chk(illegal === 1'b0, {tag, " R3 pulse one cycle"}, 128'(illegal), 128'd0);
    repeat (5) @(negedge clk);
    chk(n_req == base && we_cnt == we0, {tag, " R3 no access"},
        128'(n_req - base + we_cnt - we0), 128'd0);
  endtask

  task automatic test_busy;
    logic [31:0]  ea;
    logic [127:0] exp_v;
    int base, we0, cyc;
    bit ready_low;
    lat = 2;
    gpr[22] = 64'h3000; gpr[23] = 64'h44;
    gpr[24] = 64'h9990; gpr[25] = 64'h0;
    ea = ref_ea(22, 23);
    for (int i = 0; i < 16; i++) exp_v[127-8*i -: 8] = mem_f(ea + 32'(i));
    @(negedge clk);
    base = n_req; we0 = we_cnt;
    insn_word = std_word(8, 22, 23); insn_valid = 1'b1;
    @(negedge clk);
    insn_word = std_word(9, 24, 25);
    ready_low = 1;
    cyc = 0;
    while (done !== 1'b1 && cyc < 500) begin
      if (insn_ready !== 1'b0) ready_low = 0;
      @(negedge clk); cyc++;
    end
    insn_valid = 1'b0;
    chk(ready_low, "busy R9 ready low while busy", 128'(ready_low), 128'd1);
    chk(vr_idx == 7'd8 && vr_data == exp_v, "busy R9 first result kept", vr_data, exp_v);
    repeat (30) @(negedge clk);
    chk(n_req - base == 16 && we_cnt - we0 == 1, "busy R9 no second load",
        128'(n_req - base), 128'd16);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) gpr[i] = 64'h0101_0101_0000_0000 * 64'(i + 1);
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_std_basic();
    test_unaligned();
    test_zero_base();
    test_wrap();
    test_ext();
    test_illegal(32'h7C0000CF, "lsb set");
    test_illegal(32'h7C0000CC, "sub-opcode 102");
    test_illegal(32'h100000C0 | (32'd5 << 21), "ext reserved 00");
    test_illegal(32'h0000_0000, "zero word");
    test_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule